// File: doc/BRIEF.md
# Bank Row-Buffer Access Controller

This block models the timing of one DRAM bank that has a single row buffer. It takes one read or write at a time, each carrying a row and a column. It compares the row with the state of the buffer and sorts the access into one of three classes. A hit is a request to the row already held open. An empty access finds no row in the buffer. A conflict is a request to a row other than the one held open. After the latency that belongs to the class, counted in clock cycles, the block raises a single-cycle completion pulse and reports the class with it.

A parameter fixes the page policy at elaboration. The open-page variant leaves the row in the buffer after each access, so later accesses to the same row are cheap, and accesses to another row pay for precharge, activate and transfer. The close-page variant starts a precharge as soon as each access completes. Every access then finds an empty buffer, and the precharge only costs time when the next request arrives before it has finished. Latencies are set as a number of units, with `UNIT_CYC` clock cycles per unit.

Top module: `pgbank_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `done` is 0, and the bank holds no open row, so the first access is classed as empty.
- R2: Only one request is in flight. A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle on, and it returns to 1 in the cycle in which `done` is high. A request offered while `req_ready` is 0 is ignored: it opens no row and produces no completion.
- R3: `done` is high for exactly one cycle per accepted request.
- R4: While `done` is high, `done_class` gives the class: 0 = empty, 1 = hit, 2 = conflict. The value 3 never appears.
- R5: Latency is the number of rising edges from the accepting edge to the edge after which `done` is high. For a hit it is HIT_UNITS*UNIT_CYC, which is 4 by default.
- R6: An empty access with no pending precharge has a latency of EMPTY_UNITS*UNIT_CYC, which is 8 by default.
- R7: A conflict has a latency of CONFLICT_UNITS*UNIT_CYC, which is 12 by default.
- R8: Under the open-page policy, the requested row is open after each access. A later access to that row is a hit, and an access to any other row is a conflict that leaves the new row open.
- R9: Under the close-page policy, every access is classed as empty.
- R10: Under the close-page policy, let P = PRE_UNITS*UNIT_CYC (4 by default), and let t be the number of edges from the completion edge of one access to the accepting edge of the next. The next access then takes EMPTY_UNITS*UNIT_CYC + max(0, P - t) cycles.
- R11: Reads and writes receive the same class and the same latency. `done_write` and `done_col` return the accepted request's direction and column while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| req_ready | output | 1 | The bank can take a request |
| done | output | 1 | One-cycle completion pulse |
| done_class | output | 2 | Class of the completed access (0 empty, 1 hit, 2 conflict) |
| done_write | output | 1 | Direction of the completed access |
| done_col | output | COL_W | Column of the completed access |

## Verification
The bench goes after cases where the buffer state must carry over from one access to the next. These are: a hit right after a conflict, a return to an older row, and an access after reset to a row that was open before reset. A design that updated the open row on the wrong event, or kept it across reset, would report a hit where a conflict or an empty access is due. In the close-page instance, requests arrive at several gaps after a completion. A design that charged precharge in full, charged nothing, or counted the gap one cycle off would miss the R10 latencies. A request held on the inputs while the bank is busy must not be taken. A design that accepted it would produce an extra pulse, or leave that row open, and the following hit would be wrong.

// File: rtl/pgbank_pkg.sv
package pgbank_pkg;

   typedef enum logic [1:0] {
      ACC_EMPTY    = 2'd0,
      ACC_HIT      = 2'd1,
      ACC_CONFLICT = 2'd2
   } acc_class_e;

endpackage

// File: rtl/pgbank_rowbuf.sv
module pgbank_rowbuf #(
   parameter int ROW_W      = 8,
   parameter bit CLOSE_PAGE = 1'b0,
   parameter int PRE_CYC    = 4,
   parameter int PRE_W      = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc,
   input  logic [ROW_W-1:0] acc_row,
   input  logic             fin,
   output logic             open_vld,
   output logic [ROW_W-1:0] open_row,
   output logic [PRE_W-1:0] pre_left
);

   generate
      if (CLOSE_PAGE) begin : g_close
         logic [PRE_W-1:0] pre_q;
         logic             unused_in;

         assign unused_in = acc ^ (^acc_row);
         assign open_vld  = 1'b0;
         assign open_row  = '0;
         assign pre_left  = pre_q;

         // precharge starts at the completion edge, one cycle already spent
         always_ff @(posedge clk) begin
            if (!rst_n)
               pre_q <= '0;
            else if (fin)
               pre_q <= PRE_W'(PRE_CYC - 1);
            else if (pre_q != '0)
               pre_q <= pre_q - 1'b1;
         end
      end else begin : g_open
         logic             vld_q;
         logic [ROW_W-1:0] row_q;
         logic             unused_fin;

         assign unused_fin = fin;
         assign open_vld   = vld_q;
         assign open_row   = row_q;
         assign pre_left   = '0;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               row_q <= '0;
            end else if (acc) begin
               vld_q <= 1'b1;
               row_q <= acc_row;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pgbank_classify.sv
module pgbank_classify
   import pgbank_pkg::*;
#(
   parameter int ROW_W          = 8,
   parameter int UNIT_CYC       = 2,
   parameter int HIT_UNITS      = 2,
   parameter int EMPTY_UNITS    = 4,
   parameter int CONFLICT_UNITS = 6,
   parameter int PRE_W          = 3,
   parameter int LAT_W          = 5
) (
   input  logic             open_vld,
   input  logic [ROW_W-1:0] open_row,
   input  logic [ROW_W-1:0] req_row,
   input  logic [PRE_W-1:0] pre_left,
   output acc_class_e       cls,
   output logic [LAT_W-1:0] start_val
);

   localparam int HIT_CYC   = HIT_UNITS * UNIT_CYC;
   localparam int EMPTY_CYC = EMPTY_UNITS * UNIT_CYC;
   localparam int CONF_CYC  = CONFLICT_UNITS * UNIT_CYC;

   logic [LAT_W-1:0] base;

   always_comb begin
      if (!open_vld) begin
         cls  = ACC_EMPTY;
         base = LAT_W'(EMPTY_CYC);
      end else if (open_row == req_row) begin
         cls  = ACC_HIT;
         base = LAT_W'(HIT_CYC);
      end else begin
         cls  = ACC_CONFLICT;
         base = LAT_W'(CONF_CYC);
      end
      // counter runs from start_val down to zero, so one less than the latency
      start_val = base + LAT_W'(pre_left) - 1'b1;
   end

endmodule

// File: rtl/pgbank_timer.sv
module pgbank_timer #(
   parameter int LAT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LAT_W-1:0] start_val,
   output logic             busy,
   output logic             fin
);

   logic [LAT_W-1:0] cnt_q;
   logic             busy_q;

   assign busy = busy_q;
   assign fin  = busy_q && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= start_val;
      end else if (busy_q) begin
         if (cnt_q == '0)
            busy_q <= 1'b0;
         else
            cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/pgbank_ctrl.sv
module pgbank_ctrl
   import pgbank_pkg::*;
#(
   parameter int ROW_W          = 8,
   parameter int COL_W          = 6,
   parameter int UNIT_CYC       = 2,
   parameter bit CLOSE_PAGE     = 1'b0,
   parameter int HIT_UNITS      = 2,
   parameter int EMPTY_UNITS    = 4,
   parameter int CONFLICT_UNITS = 6,
   parameter int PRE_UNITS      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [ROW_W-1:0] req_row,
   input  logic [COL_W-1:0] req_col,
   output logic             req_ready,
   output logic             done,
   output logic [1:0]       done_class,
   output logic             done_write,
   output logic [COL_W-1:0] done_col
);

   localparam int PRE_CYC = PRE_UNITS * UNIT_CYC;
   localparam int MAX_LAT = (CONFLICT_UNITS + PRE_UNITS) * UNIT_CYC;
   localparam int PRE_W   = $clog2(PRE_CYC + 1);
   localparam int LAT_W   = $clog2(MAX_LAT + 1);

   generate
      if (ROW_W < 1 || COL_W < 1) begin : g_bad_width
         $error("pgbank_ctrl: address widths must be at least 1");
      end
      if (UNIT_CYC < 1 || HIT_UNITS < 1) begin : g_bad_unit
         $error("pgbank_ctrl: unit and hit latency must be at least 1");
      end
      if (!(HIT_UNITS < EMPTY_UNITS && EMPTY_UNITS < CONFLICT_UNITS)) begin : g_bad_order
         $error("pgbank_ctrl: latencies must rise from hit to empty to conflict");
      end
      if (PRE_CYC < 2) begin : g_bad_pre
         $error("pgbank_ctrl: precharge must last at least two cycles");
      end
   endgenerate

   logic             acc, busy, fin;
   logic             open_vld;
   logic [ROW_W-1:0] open_row;
   logic [PRE_W-1:0] pre_left;
   acc_class_e       cls;
   logic [LAT_W-1:0] start_val;

   logic             done_q, wr_q;
   acc_class_e       cls_q;
   logic [COL_W-1:0] col_q;

   assign req_ready = !busy;
   assign acc       = req_valid && req_ready;

   pgbank_rowbuf #(
      .ROW_W     (ROW_W),
      .CLOSE_PAGE(CLOSE_PAGE),
      .PRE_CYC   (PRE_CYC),
      .PRE_W     (PRE_W)
   ) u_rowbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc     (acc),
      .acc_row (req_row),
      .fin     (fin),
      .open_vld(open_vld),
      .open_row(open_row),
      .pre_left(pre_left)
   );

   pgbank_classify #(
      .ROW_W         (ROW_W),
      .UNIT_CYC      (UNIT_CYC),
      .HIT_UNITS     (HIT_UNITS),
      .EMPTY_UNITS   (EMPTY_UNITS),
      .CONFLICT_UNITS(CONFLICT_UNITS),
      .PRE_W         (PRE_W),
      .LAT_W         (LAT_W)
   ) u_classify (
      .open_vld (open_vld),
      .open_row (open_row),
      .req_row  (req_row),
      .pre_left (pre_left),
      .cls      (cls),
      .start_val(start_val)
   );

   pgbank_timer #(
      .LAT_W(LAT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (acc),
      .start_val(start_val),
      .busy     (busy),
      .fin      (fin)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         cls_q  <= ACC_EMPTY;
         wr_q   <= 1'b0;
         col_q  <= '0;
      end else begin
         done_q <= fin;
         if (acc) begin
            cls_q <= cls;
            wr_q  <= req_write;
            col_q <= req_col;
         end
      end
   end

   assign done       = done_q;
   assign done_class = cls_q;
   assign done_write = wr_q;
   assign done_col   = col_q;

endmodule

// File: rtl/pgbank_chk.sv
module pgbank_chk #(
   parameter int UNIT_CYC       = 2,
   parameter bit CLOSE_PAGE     = 1'b0,
   parameter int HIT_UNITS      = 2,
   parameter int EMPTY_UNITS    = 4,
   parameter int CONFLICT_UNITS = 6,
   parameter int PRE_UNITS      = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       done,
   input logic [1:0] done_class
);

   localparam int HIT_CYC   = HIT_UNITS * UNIT_CYC;
   localparam int EMPTY_CYC = EMPTY_UNITS * UNIT_CYC;
   localparam int CONF_CYC  = CONFLICT_UNITS * UNIT_CYC;
   localparam int PRE_CYC   = PRE_UNITS * UNIT_CYC;

   // edges since the accepting edge, saturating
   logic [15:0] lat_c;
   always_ff @(posedge clk) begin
      if (!rst_n)
         lat_c <= '0;
      else if (req_valid && req_ready)
         lat_c <= '0;
      else if (lat_c != 16'hFFFF)
         lat_c <= lat_c + 1'b1;
   end

   AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R2
   AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready); // R2
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R3
   AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (done_class != 2'd3)); // R4

   generate
      if (CLOSE_PAGE) begin : g_close_chk
         AST_CLOSE_ALWAYS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> (done_class == 2'd0)); // R9
         AST_CLOSE_WAIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> (lat_c >= 16'(EMPTY_CYC) && lat_c <= 16'(EMPTY_CYC + PRE_CYC - 1))); // R10
      end else begin : g_open_chk
         AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            (done && done_class == 2'd1) |-> (lat_c == 16'(HIT_CYC))); // R5
         AST_EMPTY_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            (done && done_class == 2'd0) |-> (lat_c == 16'(EMPTY_CYC))); // R6
         AST_CONFLICT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            (done && done_class == 2'd2) |-> (lat_c == 16'(CONF_CYC))); // R7
      end
   endgenerate

endmodule

bind pgbank_ctrl pgbank_chk #(
   .UNIT_CYC      (UNIT_CYC),
   .CLOSE_PAGE    (CLOSE_PAGE),
   .HIT_UNITS     (HIT_UNITS),
   .EMPTY_UNITS   (EMPTY_UNITS),
   .CONFLICT_UNITS(CONFLICT_UNITS),
   .PRE_UNITS     (PRE_UNITS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .done      (done),
   .done_class(done_class)
);

// File: tb/pgbank_ctrl_test.sv
module pgbank_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] row = '0;
   logic [5:0] col = '0;
   logic       valid_op = 1'b0, valid_cp = 1'b0;

   logic       rdy_op, done_op, dwr_op;
   logic [1:0] cls_op;
   logic [5:0] dcol_op;
   logic       rdy_cp, done_cp, dwr_cp;
   logic [1:0] cls_cp;
   logic [5:0] dcol_cp;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk; // 50 MHz

   pgbank_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(valid_op), .req_write(wr),
      .req_row(row), .req_col(col), .req_ready(rdy_op), .done(done_op),
      .done_class(cls_op), .done_write(dwr_op), .done_col(dcol_op)
   );

   pgbank_ctrl #(.CLOSE_PAGE(1'b1)) uut_cp (
      .clk(clk), .rst_n(rst_n), .req_valid(valid_cp), .req_write(wr),
      .req_row(row), .req_col(col), .req_ready(rdy_cp), .done(done_cp),
      .done_class(cls_cp), .done_write(dwr_cp), .done_col(dcol_cp)
   );

   // fields: cp | wr | row[7:0] | gap[3:0] | class[1:0] | latency[7:0]
   localparam int NV = 14;
   localparam logic [23:0] VEC [NV] = '{
      {1'b0, 1'b0, 8'h05, 4'd0, 2'd0, 8'd8},
      {1'b0, 1'b1, 8'h05, 4'd0, 2'd1, 8'd4},
      {1'b0, 1'b0, 8'h05, 4'd2, 2'd1, 8'd4},
      {1'b0, 1'b0, 8'h09, 4'd0, 2'd2, 8'd12},
      {1'b0, 1'b1, 8'h09, 4'd1, 2'd1, 8'd4},
      {1'b0, 1'b0, 8'h05, 4'd0, 2'd2, 8'd12},
      {1'b0, 1'b1, 8'h00, 4'd0, 2'd2, 8'd12},
      {1'b0, 1'b0, 8'h00, 4'd3, 2'd1, 8'd4},
      {1'b1, 1'b0, 8'h05, 4'd0, 2'd0, 8'd8},
      {1'b1, 1'b0, 8'h05, 4'd0, 2'd0, 8'd11},
      {1'b1, 1'b1, 8'h07, 4'd1, 2'd0, 8'd10},
      {1'b1, 1'b0, 8'h07, 4'd2, 2'd0, 8'd9},
      {1'b1, 1'b0, 8'h07, 4'd3, 2'd0, 8'd8},
      {1'b1, 1'b1, 8'h03, 4'd6, 2'd0, 8'd8}
   };

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic run_req(input bit cp, input bit w, input logic [7:0] r,
                          input logic [5:0] c, input int gap,
                          input int ecls, input int elat, input string tag);
      int n;
      repeat (gap) @(negedge clk);
      wr = w; row = r; col = c;
      if (cp) valid_cp = 1'b1; else valid_op = 1'b1;
      while (!(cp ? rdy_cp : rdy_op)) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      valid_op = 1'b0; valid_cp = 1'b0;
      n = 0;
      while (!(cp ? done_cp : done_op) && n < 100) begin
         @(negedge clk);
         n++;
      end
      check({tag, " latency"}, n, elat);
      check({tag, " class"}, int'(cp ? cls_cp : cls_op), ecls);
      check({tag, " write/col R11"}, int'({cp ? dwr_cp : dwr_op, cp ? dcol_cp : dcol_op}),
            int'({w, c}));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      string tag;
      int    quiet;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 ready open", int'(rdy_op), 1);
      check("R1 ready close", int'(rdy_cp), 1);
      check("R1 done open", int'(done_op), 0);
      check("R1 done close", int'(done_cp), 0);

      for (int i = 0; i < NV; i++) begin
         logic [23:0] v;
         v = VEC[i];
         if (v[23]) tag = (v[15:12] >= 4'd3 || i == 8) ? "R9 R6" : "R10";
         else if (i == 0) tag = "R1 R6";
         else if (v[9:8] == 2'd1) tag = "R5 R8";
         else tag = "R7 R8";
         run_req(v[23], v[22], v[21:14], 6'(i), int'(v[13:10]),
                 int'(v[9:8]), int'(v[7:0]), tag);
      end

      // R2: a request held while busy is ignored
      fork
         run_req(1'b0, 1'b0, 8'h22, 6'd40, 0, 2, 12, "R7 R2");
         begin
            repeat (3) @(negedge clk);
            valid_op = 1'b1; row = 8'h33;
            repeat (3) begin
               check("R2 ready low while busy", int'(rdy_op), 0);
               @(negedge clk);
            end
            valid_op = 1'b0; row = 8'h22;
         end
      join
      @(negedge clk);
      check("R3 done lasts one cycle", int'(done_op), 0);
      quiet = 0;
      repeat (20) begin
         @(negedge clk);
         if (done_op) quiet++;
      end
      check("R2 no completion for ignored request", quiet, 0);
      run_req(1'b0, 1'b0, 8'h22, 6'd41, 0, 1, 4, "R2 R8 hit on original row");

      // R1: reset clears the open row
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready after reset", int'(rdy_op), 1);
      run_req(1'b0, 1'b1, 8'h22, 6'd42, 0, 0, 8, "R1 empty after reset");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule